// File: doc/BRIEF.md
# Priority-Level Interrupt Queue Arbiter

This block keeps pending interrupt requests sorted into eight priority levels. Each request carries an 8-bit vector and a 3-bit level, and each level keeps a small set of distinct pending vectors. When the processor reaches an instruction boundary it pulses the service strobe together with its current priority. The arbiter then picks at most one pending request that this priority allows, removes it from its level and reports it on the grant outputs one cycle later.

The scan always moves from lower level numbers to higher ones. Its first level depends on a threshold. At a current priority of 3 or below, every level is eligible. Above 3, only levels strictly above the current priority are eligible. Inside the chosen level, the numerically smallest vector wins. The granted level is the processor's new priority.

Building the trap frame and fetching through the vector are handled outside this block.

Top module: `ipq_arbiter`

## Requirements
- R1: After reset no vector is pending in any level, and grant_valid and overflow are both 0.
- R2: With cur_ipl at 3 or below, levels 0 to 7 are all eligible. With cur_ipl above 3, only levels numbered greater than cur_ipl are eligible, so cur_ipl = 7 never gets a grant.
- R3: Among the eligible levels that hold a pending vector, the lowest-numbered one is served, and grant_level gives its number. That number is the new processor priority.
- R4: Within the served level, the smallest pending vector is granted on grant_vector and removed from the level.
- R5: A service strobe in cycle N produces at most one grant. grant_valid is high in cycle N+1 exactly when some eligible level held a vector in cycle N.
- R6: A request whose vector is already pending at the same level is absorbed. It leaves no second copy, so only one grant can come from it.
- R7: Each level holds up to 8 distinct vectors. A new vector sent to a full level is dropped, and overflow is high for exactly the following cycle.
- R8: If a request and a service strobe fall in the same cycle, the grant is chosen from the state before that cycle's request. The removal is applied first and the request second. A slot freed by the grant can therefore take the request, and a request for the vector being granted is queued again.
- R9: Without a service strobe, no grant is issued and no pending vector is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe for one cycle |
| req_level | input | 3 | Priority level of the request |
| req_vector | input | 8 | Vector of the request |
| cur_ipl | input | 3 | Current processor priority |
| check | input | 1 | Service strobe at an instruction boundary |
| grant_valid | output | 1 | A grant was made for the previous cycle's strobe |
| grant_vector | output | 8 | Granted vector |
| grant_level | output | 3 | Granted level, which is the new processor priority |
| overflow | output | 1 | The previous cycle's request was dropped because its level was full |

## Verification
The hardest situation to reach is a full level that receives a new request in the same cycle that a grant takes one of its vectors. The result depends on whether the removal or the insertion is applied first. The bench fills one level to its capacity and confirms the overflow with a ninth request. It then issues a service strobe and a fresh request to that level in one cycle, and drains the level so the outcome shows on grant_vector. A random phase then uses a narrow vector range, so duplicates, full levels and simultaneous events occur often. A behavioural set model is compared against the outputs on every cycle.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  // First level the scan may consider for a given current priority.
  // At or below the threshold every level is open; above it only
  // levels strictly higher than the current priority are.
  function automatic int unsigned scan_start(input int unsigned ipl,
                                             input int unsigned thresh);
    return (ipl <= thresh) ? 0 : ipl + 1;
  endfunction
endpackage

// File: rtl/ipq_level.sv
module ipq_level #(
  parameter int VEC_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [VEC_W-1:0] ins_vec,
  input  logic             rm_en,
  output logic             pending,
  output logic [VEC_W-1:0] min_vec,
  output logic             drop
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid_q;
  logic [VEC_W-1:0] vec_q [DEPTH];

  logic [IW-1:0]    best_idx;
  logic [IW-1:0]    free_idx;
  logic             has_free;
  logic             dup;
  logic             accept;
  logic [DEPTH-1:0] post_valid;
  logic [DEPTH-1:0] next_valid;

  // smallest pending vector and the slot that holds it
  always_comb begin
    best_idx = '0;
    min_vec  = '1;
    pending  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && (!pending || vec_q[i] < min_vec)) begin
        pending  = 1'b1;
        min_vec  = vec_q[i];
        best_idx = IW'(i);
      end
    end
  end

  // removal first, then the request sees the remaining set
  always_comb begin
    post_valid = valid_q;
    if (rm_en && pending) post_valid[best_idx] = 1'b0;
    dup      = 1'b0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (post_valid[i] && vec_q[i] == ins_vec) dup = 1'b1;
      if (!post_valid[i] && !has_free) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
    end
    accept     = ins_en && !dup && has_free;
    drop       = ins_en && !dup && !has_free;
    next_valid = post_valid;
    if (accept) next_valid[free_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= next_valid;
  end

  always_ff @(posedge clk) begin
    if (accept) vec_q[free_idx] <= ins_vec;
  end
endmodule

// File: rtl/ipq_pick.sv
module ipq_pick #(
  parameter int LEVELS = 8,
  parameter int THRESH = 3,
  localparam int LW    = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] pend_mask,
  input  logic [LW-1:0]     cur_ipl,
  output logic              found,
  output logic [LW-1:0]     sel
);
  import ipq_pkg::*;

  int unsigned start;

  always_comb begin
    start = scan_start(int'(cur_ipl), THRESH);
    found = 1'b0;
    sel   = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (!found && pend_mask[l] && l >= int'(start)) begin
        found = 1'b1;
        sel   = LW'(l);
      end
    end
  end
endmodule

// File: rtl/ipq_arbiter.sv
module ipq_arbiter #(
  parameter int LEVELS = 8,
  parameter int VEC_W  = 8,
  parameter int DEPTH  = 8,
  parameter int THRESH = 3,
  localparam int LW    = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LW-1:0]    req_level,
  input  logic [VEC_W-1:0] req_vector,
  input  logic [LW-1:0]    cur_ipl,
  input  logic             check,
  output logic             grant_valid,
  output logic [VEC_W-1:0] grant_vector,
  output logic [LW-1:0]    grant_level,
  output logic             overflow
);
  logic [LEVELS-1:0] pend_mask;
  logic [LEVELS-1:0] rm_en;
  logic [LEVELS-1:0] drop;
  logic [VEC_W-1:0]  lvl_min [LEVELS];
  logic              found;
  logic              take;
  logic [LW-1:0]     sel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    ipq_level #(.VEC_W(VEC_W), .DEPTH(DEPTH)) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .ins_en (req_valid && req_level == LW'(g)),
      .ins_vec(req_vector),
      .rm_en  (rm_en[g]),
      .pending(pend_mask[g]),
      .min_vec(lvl_min[g]),
      .drop   (drop[g])
    );
    assign rm_en[g] = take && sel == LW'(g);
  end

  ipq_pick #(.LEVELS(LEVELS), .THRESH(THRESH)) u_pick (
    .pend_mask(pend_mask),
    .cur_ipl  (cur_ipl),
    .found    (found),
    .sel      (sel)
  );

  assign take = check && found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid  <= 1'b0;
      grant_vector <= '0;
      grant_level  <= '0;
      overflow     <= 1'b0;
    end else begin
      grant_valid <= take;
      overflow    <= |drop;
      if (take) begin
        grant_vector <= lvl_min[sel];
        grant_level  <= sel;
      end
    end
  end
endmodule

// File: rtl/ipq_arbiter_chk.sv
module ipq_arbiter_chk #(
  parameter int LEVELS = 8,
  parameter int THRESH = 3,
  localparam int LW    = $clog2(LEVELS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              check,
  input logic              req_valid,
  input logic [LW-1:0]     cur_ipl,
  input logic              grant_valid,
  input logic [LW-1:0]     grant_level,
  input logic              overflow,
  input logic [LEVELS-1:0] pend_mask,
  input logic [LEVELS-1:0] rm_en
);
  a_r9_no_grant_without_check: assert property (@(posedge clk) disable iff (!rst_n)
    !check |=> !grant_valid);

  a_r2_above_current: assert property (@(posedge clk) disable iff (!rst_n)
    (check && int'(cur_ipl) > THRESH) |=> (!grant_valid || grant_level > $past(cur_ipl)));

  a_r3_level0_first: assert property (@(posedge clk) disable iff (!rst_n)
    (check && pend_mask[0] && int'(cur_ipl) <= THRESH) |=> (grant_valid && grant_level == '0));

  a_r5_single_removal: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rm_en));

  a_r5_grant_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (check && pend_mask != '0 && int'(cur_ipl) <= THRESH) |=> grant_valid);

  a_r7_overflow_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !overflow);
endmodule

bind ipq_arbiter ipq_arbiter_chk #(.LEVELS(LEVELS), .THRESH(THRESH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .check      (check),
  .req_valid  (req_valid),
  .cur_ipl    (cur_ipl),
  .grant_valid(grant_valid),
  .grant_level(grant_level),
  .overflow   (overflow),
  .pend_mask  (pend_mask),
  .rm_en      (rm_en)
);

// File: tb/tb_ipq_arbiter.sv
module tb_ipq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_level = '0;
  logic [7:0] req_vector = '0;
  logic [2:0] cur_ipl = '0;
  logic       check = 1'b0;
  logic       grant_valid;
  logic [7:0] grant_vector;
  logic [2:0] grant_level;
  logic       overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit [255:0] pend [8];

  always #10 clk = ~clk;

  ipq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .req_vector(req_vector), .cur_ipl(cur_ipl), .check(check),
    .grant_valid(grant_valid), .grant_vector(grant_vector),
    .grant_level(grant_level), .overflow(overflow)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, advance the set model, compare after the edge
  task automatic step(input bit rv, input int rl, input int rvec,
                      input bit chk, input int ipl, input string tag);
    bit eg = 0, eo = 0;
    int el = 0, ev = 0, st;
    req_valid  = rv;
    req_level  = 3'(rl);
    req_vector = 8'(rvec);
    check      = chk;
    cur_ipl    = 3'(ipl);
    if (chk) begin
      st = (ipl <= 3) ? 0 : ipl + 1;
      for (int l = st; l < 8; l++) begin
        if (!eg && pend[l] != '0) begin
          for (int v = 0; v < 256; v++) begin
            if (!eg && pend[l][v]) begin
              eg = 1; el = l; ev = v;
            end
          end
        end
      end
      if (eg) pend[el][ev] = 1'b0;
    end
    if (rv && !pend[rl][rvec]) begin
      if ($countones(pend[rl]) >= 8) eo = 1;
      else pend[rl][rvec] = 1'b1;
    end
    @(posedge clk);
    #5;
    cmp(tag, "grant_valid", int'(grant_valid), int'(eg));
    if (eg) begin
      cmp(tag, "grant_vector", int'(grant_vector), ev);
      cmp(tag, "grant_level", int'(grant_level), el);
    end
    cmp(tag, "overflow", int'(overflow), int'(eo));
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 8; l++) pend[l] = '0;
    repeat (3) @(posedge clk);
    #5;
    cmp("R1", "grant_valid in reset", int'(grant_valid), 0);
    cmp("R1", "overflow in reset", int'(overflow), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 0, "R1");           // empty after reset: no grant

    // R4: smallest vector first, each removed once granted
    step(1, 2, 8'h40, 0, 0, "R4");
    step(1, 2, 8'h10, 0, 0, "R4");
    step(1, 2, 8'h30, 0, 0, "R4");
    step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 1, 0, "R4");

    // R3: lowest eligible level first; R2 threshold rule
    step(1, 5, 8'h55, 0, 0, "R3");
    step(1, 1, 8'h11, 0, 0, "R3");
    step(0, 0, 0, 1, 0, "R3");           // level 1
    step(1, 1, 8'h12, 0, 0, "R2");
    step(0, 0, 0, 1, 3, "R2");           // ipl 3 still opens level 1
    step(0, 0, 0, 1, 5, "R2");           // level 5 blocked at ipl 5
    step(0, 0, 0, 1, 4, "R2");           // open at ipl 4
    step(1, 7, 8'h77, 0, 0, "R2");
    step(0, 0, 0, 1, 7, "R2");           // nothing above 7
    step(0, 0, 0, 1, 6, "R2");

    // R9: no strobe, nothing leaves
    step(1, 4, 8'h09, 0, 0, "R9");
    idle("R9");
    idle("R9");
    step(0, 0, 0, 1, 0, "R9");

    // R6: duplicates absorbed
    step(1, 3, 8'h22, 0, 0, "R6");
    step(1, 3, 8'h22, 0, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 1, 0, "R6");

    // R7: fill level 6, ninth distinct vector dropped
    for (int k = 0; k < 8; k++) step(1, 6, 8'h80 + k, 0, 0, "R7");
    step(1, 6, 8'hF0, 0, 0, "R7");
    step(1, 6, 8'h81, 0, 0, "R7");        // duplicate on a full level: no flag
    idle("R7");

    // R8: full level, grant and new request together -> accepted
    step(1, 6, 8'hF1, 1, 0, "R8");
    // re-request of the vector being granted is queued again
    step(1, 6, 8'h81, 1, 0, "R8");
    for (int k = 0; k < 10; k++) step(0, 0, 0, 1, 0, "R8");

    // random phase with a narrow vector range
    for (int n = 0; n < 600; n++) begin
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 11)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, 7)), "R5");
    end
    for (int k = 0; k < 70; k++) step(0, 0, 0, 1, 0, "R5");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule